// File: doc/BRIEF.md
# Register Rename Map with Sequential History Rollback

This block keeps the architectural-to-physical register mapping for one thread of an out-of-order core. Each rename request can name several source registers and up to one destination register. For each source it returns the physical register that the source maps to now, and a ready flag read from a per-physical-register scoreboard. For the destination it takes a fresh physical register from a FIFO free list. It marks that register not-ready and points the map at it. It also logs the change in a history ring as a tuple of sequence number, architectural register, new physical register and previous physical register.

Recovery walks the history ring one entry per cycle, with no checkpoints. A squash walks from the young end and undoes each mapping younger than the squash point. It restores the previous physical register and frees the new one. A commit walks from the old end and retires every entry at or below the committed sequence number, freeing the previous physical register. A writeback port sets scoreboard ready bits. While a walk is running, the `busy` output is high and new rename requests are refused.

Top module: `rnm_rename_map`

## Requirements
- R1: After reset every architectural register i maps to physical register i, every physical register reads ready, and `busy` is low.
- R2: Each source lookup returns, in the same cycle, the physical register currently mapped to that architectural index. Its ready flag equals that register's scoreboard bit.
- R3: An accepted rename with a destination takes physical registers in the free list's FIFO order, which starts at ARCH_N and counts upward. It reports the old mapping on `ren_prev_phys`. From the next cycle the destination maps to the new register, and that register reads not-ready.
- R4: A writeback of physical register p makes p read ready from the following cycle.
- R5: `ren_accept` is high only when no walk is running, neither squash nor commit is signalled that cycle, and the free list holds at least as many registers as the request has destinations (0 or 1). A request without a destination is accepted even when the free list is empty.
- R6: A squash to sequence S removes history entries from the young end, one per cycle, while their sequence number is greater than S. Each removal restores the map to the previous register and appends the new register to the tail of the free list. `busy` is high for the whole walk.
- R7: A commit of sequence N removes history entries from the old end, one per cycle, while their sequence number is at most N. Each removal appends the previous register to the free list. The mappings stay as they are.
- R8: A commit is ignored when the history is empty or its oldest entry is younger than N. A squash on an empty history changes no mapping.
- R9: A commit signalled in the same cycle as a squash, or during a squash walk, is ignored. A squash arriving during a commit walk ends that walk and starts the squash.
- R10: The free-list count plus the history count always equals PHYS_N - ARCH_N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | Rename request present |
| ren_src_arch | input | SRC_N x AW | Source architectural indices |
| ren_dst_valid | input | 1 | Request has a destination |
| ren_dst_arch | input | AW | Destination architectural index |
| ren_seq | input | SEQ_W | Sequence number of the request |
| ren_accept | output | 1 | Request taken this cycle |
| ren_src_phys | output | SRC_N x PW | Mapped physical register per source |
| ren_src_ready | output | SRC_N | Ready flag per source |
| ren_dst_phys | output | PW | Newly allocated physical register |
| ren_prev_phys | output | PW | Previous mapping of the destination |
| cmt_valid | input | 1 | Commit signalled |
| cmt_seq | input | SEQ_W | Committed sequence number |
| sq_valid | input | 1 | Squash signalled |
| sq_seq | input | SEQ_W | Last surviving sequence number |
| wb_valid | input | 1 | Writeback present |
| wb_phys | input | PW | Physical register written back |
| busy | output | 1 | Squash or commit walk running |

## Verification
Source lookups, `ren_accept` and the allocated and previous registers are combinational, so the bench reads them one time unit after driving the request at the falling edge, before the edge that registers them. Map updates, scoreboard clears and writeback sets appear after one rising edge, and the bench reads them at the next falling edge. A squash or commit needs one edge to start the walk and one more edge per removed entry, plus a final edge to return to idle. The bench therefore polls `busy` at falling edges and checks mappings only after it drops. It also samples `busy` and `ren_accept` in the first walk cycle to catch a missing stall.

// File: rtl/rnm_pkg.sv
package rnm_pkg;

    localparam int DEF_ARCH_N = 8;
    localparam int DEF_PHYS_N = 16;
    localparam int DEF_SEQ_W  = 8;
    localparam int DEF_SRC_N  = 2;

    typedef enum logic [1:0] {
        WK_IDLE   = 2'd0,
        WK_SQUASH = 2'd1,
        WK_COMMIT = 2'd2
    } walk_e;

    // Entry younger than a squash point must be undone.
    function automatic logic seq_after(input logic [31:0] a, input logic [31:0] b);
        return a > b;
    endfunction

endpackage

// File: rtl/rnm_map_table.sv
module rnm_map_table #(
    parameter int ARCH_N = 8,
    parameter int PHYS_N = 16,
    parameter int SRC_N  = 2,
    localparam int AW = $clog2(ARCH_N),
    localparam int PW = $clog2(PHYS_N)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [SRC_N-1:0][AW-1:0]  rd_arch,
    output logic [SRC_N-1:0][PW-1:0]  rd_phys,
    input  logic [AW-1:0]             dst_arch,
    output logic [PW-1:0]             dst_phys,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_arch,
    input  logic [PW-1:0]             wr_phys
);
    logic [PW-1:0] map_q [ARCH_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ARCH_N; i++) map_q[i] <= PW'(i);
        end else if (wr_en) begin
            map_q[wr_arch] <= wr_phys;
        end
    end

    for (genvar s = 0; s < SRC_N; s++) begin : g_rd
        assign rd_phys[s] = map_q[rd_arch[s]];
    end
    assign dst_phys = map_q[dst_arch];
endmodule

// File: rtl/rnm_free_fifo.sv
module rnm_free_fifo #(
    parameter int PHYS_N = 16,
    parameter int FIRST  = 8,
    localparam int PW = $clog2(PHYS_N),
    localparam int CW = $clog2(PHYS_N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pop,
    output logic [PW-1:0] head_data,
    input  logic          push,
    input  logic [PW-1:0] push_data,
    output logic [CW-1:0] count
);
    localparam int INIT_N = PHYS_N - FIRST;

    logic [PW-1:0] mem_q [PHYS_N];
    logic [PW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PHYS_N; i++)
                mem_q[i] <= (i < INIT_N) ? PW'(FIRST + i) : '0;
            rd_q  <= '0;
            wr_q  <= PW'(INIT_N);
            cnt_q <= CW'(INIT_N);
        end else begin
            if (push) begin
                mem_q[wr_q] <= push_data;
                wr_q        <= wr_q + 1'b1;
            end
            if (pop) rd_q <= rd_q + 1'b1;
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head_data = mem_q[rd_q];
    assign count     = cnt_q;
endmodule

// File: rtl/rnm_ready_board.sv
module rnm_ready_board #(
    parameter int PHYS_N = 16,
    parameter int SRC_N  = 2,
    localparam int PW = $clog2(PHYS_N)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     set_en,
    input  logic [PW-1:0]            set_idx,
    input  logic                     clr_en,
    input  logic [PW-1:0]            clr_idx,
    input  logic [SRC_N-1:0][PW-1:0] rd_idx,
    output logic [SRC_N-1:0]         rd_ready
);
    logic [PHYS_N-1:0] rdy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q <= '1;
        end else begin
            if (set_en) rdy_q[set_idx] <= 1'b1;
            if (clr_en) rdy_q[clr_idx] <= 1'b0;
        end
    end

    for (genvar s = 0; s < SRC_N; s++) begin : g_rd
        assign rd_ready[s] = rdy_q[rd_idx[s]];
    end
endmodule

// File: rtl/rnm_hist_ring.sv
module rnm_hist_ring #(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 8,
    parameter int AW    = 3,
    parameter int PW    = 4,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [SEQ_W-1:0] push_seq,
    input  logic [AW-1:0]    push_arch,
    input  logic [PW-1:0]    push_new,
    input  logic [PW-1:0]    push_prev,
    input  logic             pop_young,
    input  logic             pop_old,
    output logic [SEQ_W-1:0] yng_seq,
    output logic [AW-1:0]    yng_arch,
    output logic [PW-1:0]    yng_new,
    output logic [PW-1:0]    yng_prev,
    output logic [SEQ_W-1:0] old_seq,
    output logic [PW-1:0]    old_prev,
    output logic             empty,
    output logic [CW-1:0]    count
);
    typedef struct packed {
        logic [SEQ_W-1:0] seq;
        logic [AW-1:0]    arch;
        logic [PW-1:0]    newp;
        logic [PW-1:0]    prevp;
    } hent_t;

    hent_t         ring_q [DEPTH];
    logic [IW-1:0] old_q, nxt_q;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] yng_idx;
    hent_t         yng_e, old_e;

    function automatic logic [IW-1:0] bump(input logic [IW-1:0] p, input logic up);
        if (up) return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
        else    return (p == '0) ? IW'(DEPTH - 1) : p - 1'b1;
    endfunction

    assign yng_idx = bump(nxt_q, 1'b0);
    assign yng_e   = ring_q[yng_idx];
    assign old_e   = ring_q[old_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ring_q[i] <= '0;
            old_q <= '0;
            nxt_q <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                ring_q[nxt_q] <= '{seq: push_seq, arch: push_arch,
                                   newp: push_new, prevp: push_prev};
                nxt_q <= bump(nxt_q, 1'b1);
                cnt_q <= cnt_q + 1'b1;
            end else if (pop_young) begin
                nxt_q <= yng_idx;
                cnt_q <= cnt_q - 1'b1;
            end else if (pop_old) begin
                old_q <= bump(old_q, 1'b1);
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign yng_seq  = yng_e.seq;
    assign yng_arch = yng_e.arch;
    assign yng_new  = yng_e.newp;
    assign yng_prev = yng_e.prevp;
    assign old_seq  = old_e.seq;
    assign old_prev = old_e.prevp;
    assign empty    = (cnt_q == '0);
    assign count    = cnt_q;
endmodule

// File: rtl/rnm_rename_map.sv
module rnm_rename_map #(
    parameter int ARCH_N = rnm_pkg::DEF_ARCH_N,
    parameter int PHYS_N = rnm_pkg::DEF_PHYS_N,
    parameter int SEQ_W  = rnm_pkg::DEF_SEQ_W,
    parameter int SRC_N  = rnm_pkg::DEF_SRC_N,
    localparam int AW = $clog2(ARCH_N),
    localparam int PW = $clog2(PHYS_N)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ren_valid,
    input  logic [SRC_N-1:0][AW-1:0] ren_src_arch,
    input  logic                     ren_dst_valid,
    input  logic [AW-1:0]            ren_dst_arch,
    input  logic [SEQ_W-1:0]         ren_seq,
    output logic                     ren_accept,
    output logic [SRC_N-1:0][PW-1:0] ren_src_phys,
    output logic [SRC_N-1:0]         ren_src_ready,
    output logic [PW-1:0]            ren_dst_phys,
    output logic [PW-1:0]            ren_prev_phys,
    input  logic                     cmt_valid,
    input  logic [SEQ_W-1:0]         cmt_seq,
    input  logic                     sq_valid,
    input  logic [SEQ_W-1:0]         sq_seq,
    input  logic                     wb_valid,
    input  logic [PW-1:0]            wb_phys,
    output logic                     busy
);
    import rnm_pkg::*;

    localparam int HD  = PHYS_N - ARCH_N;
    localparam int CW  = $clog2(PHYS_N + 1);
    localparam int HCW = $clog2(HD + 1);

    walk_e            st_q;
    logic [SEQ_W-1:0] tgt_q;

    logic [PW-1:0]    fl_head;
    logic [CW-1:0]    free_cnt;
    logic [HCW-1:0]   hist_cnt;
    logic             h_empty;
    logic [SEQ_W-1:0] y_seq, o_seq;
    logic [AW-1:0]    y_arch;
    logic [PW-1:0]    y_new, y_prev, o_prev;

    logic alloc, sq_step, cm_step;
    logic map_we;
    logic [AW-1:0] map_wa;
    logic [PW-1:0] map_wd;
    logic fl_push;
    logic [PW-1:0] fl_pd;

    // Acceptance and walk steps
    assign ren_accept = ren_valid && (st_q == WK_IDLE) && !sq_valid && !cmt_valid
                        && (free_cnt >= CW'(ren_dst_valid));
    assign alloc   = ren_accept && ren_dst_valid;
    assign sq_step = (st_q == WK_SQUASH) && !sq_valid && !h_empty
                     && seq_after(32'(y_seq), 32'(tgt_q));
    assign cm_step = (st_q == WK_COMMIT) && !sq_valid && !h_empty
                     && !seq_after(32'(o_seq), 32'(tgt_q));
    assign busy    = (st_q != WK_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= WK_IDLE;
            tgt_q <= '0;
        end else if (sq_valid) begin
            st_q  <= WK_SQUASH;
            tgt_q <= sq_seq;
        end else begin
            unique case (st_q)
                WK_IDLE: if (cmt_valid) begin
                    st_q  <= WK_COMMIT;
                    tgt_q <= cmt_seq;
                end
                WK_SQUASH: if (!sq_step) st_q <= WK_IDLE;
                WK_COMMIT: if (!cm_step) st_q <= WK_IDLE;
                default:   st_q <= WK_IDLE;
            endcase
        end
    end

    // Map write: either a new mapping or a restore, never both
    always_comb begin
        map_we = alloc || sq_step;
        map_wa = sq_step ? y_arch : ren_dst_arch;
        map_wd = sq_step ? y_prev : fl_head;
        fl_push = sq_step || cm_step;
        fl_pd   = sq_step ? y_new : o_prev;
    end

    rnm_map_table #(.ARCH_N(ARCH_N), .PHYS_N(PHYS_N), .SRC_N(SRC_N)) u_map (
        .clk      (clk),
        .rst      (rst),
        .rd_arch  (ren_src_arch),
        .rd_phys  (ren_src_phys),
        .dst_arch (ren_dst_arch),
        .dst_phys (ren_prev_phys),
        .wr_en    (map_we),
        .wr_arch  (map_wa),
        .wr_phys  (map_wd)
    );

    rnm_free_fifo #(.PHYS_N(PHYS_N), .FIRST(ARCH_N)) u_free (
        .clk       (clk),
        .rst       (rst),
        .pop       (alloc),
        .head_data (fl_head),
        .push      (fl_push),
        .push_data (fl_pd),
        .count     (free_cnt)
    );

    rnm_ready_board #(.PHYS_N(PHYS_N), .SRC_N(SRC_N)) u_rdy (
        .clk      (clk),
        .rst      (rst),
        .set_en   (wb_valid),
        .set_idx  (wb_phys),
        .clr_en   (alloc),
        .clr_idx  (fl_head),
        .rd_idx   (ren_src_phys),
        .rd_ready (ren_src_ready)
    );

    rnm_hist_ring #(.DEPTH(HD), .SEQ_W(SEQ_W), .AW(AW), .PW(PW)) u_hist (
        .clk       (clk),
        .rst       (rst),
        .push      (alloc),
        .push_seq  (ren_seq),
        .push_arch (ren_dst_arch),
        .push_new  (fl_head),
        .push_prev (ren_prev_phys),
        .pop_young (sq_step),
        .pop_old   (cm_step),
        .yng_seq   (y_seq),
        .yng_arch  (y_arch),
        .yng_new   (y_new),
        .yng_prev  (y_prev),
        .old_seq   (o_seq),
        .old_prev  (o_prev),
        .empty     (h_empty),
        .count     (hist_cnt)
    );

    assign ren_dst_phys = fl_head;
endmodule

// File: rtl/rnm_rename_map_chk.sv
module rnm_rename_map_chk #(
    parameter int PW  = 4,
    parameter int CW  = 5,
    parameter int HCW = 4,
    parameter int HD  = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           ren_accept,
    input logic           ren_dst_valid,
    input logic [PW-1:0]  ren_dst_phys,
    input logic [PW-1:0]  ren_prev_phys,
    input logic           sq_valid,
    input logic           cmt_valid,
    input logic           busy,
    input logic [CW-1:0]  free_cnt,
    input logic [HCW-1:0] hist_cnt
);
    // R5
    no_accept_in_walk_chk: assert property (@(posedge clk) disable iff (rst)
        ren_accept |-> !busy);

    // R5
    no_alloc_from_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (ren_accept && ren_dst_valid) |-> (free_cnt != '0));

    // R3
    fresh_reg_differs_chk: assert property (@(posedge clk) disable iff (rst)
        (ren_accept && ren_dst_valid) |-> (ren_dst_phys != ren_prev_phys));

    // R6
    squash_starts_walk_chk: assert property (@(posedge clk) disable iff (rst)
        sq_valid |=> busy);

    // R9
    walk_needs_trigger_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(sq_valid || cmt_valid));

    // R10
    reg_conservation_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(free_cnt) + 32'(hist_cnt)) == HD);
endmodule

bind rnm_rename_map rnm_rename_map_chk #(.PW(PW), .CW(CW), .HCW(HCW), .HD(HD)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ren_accept    (ren_accept),
    .ren_dst_valid (ren_dst_valid),
    .ren_dst_phys  (ren_dst_phys),
    .ren_prev_phys (ren_prev_phys),
    .sq_valid      (sq_valid),
    .cmt_valid     (cmt_valid),
    .busy          (busy),
    .free_cnt      (free_cnt),
    .hist_cnt      (hist_cnt)
);

// File: tb/rnm_rename_map_tb.sv
module rnm_rename_map_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ARCH_N = 8;
    localparam int PHYS_N = 16;
    localparam int SEQ_W  = 8;
    localparam int SRC_N  = 2;
    localparam int AW = $clog2(ARCH_N);
    localparam int PW = $clog2(PHYS_N);

    logic clk = 1'b0;
    logic rst;
    logic ren_valid, ren_dst_valid, ren_accept;
    logic [SRC_N-1:0][AW-1:0] ren_src_arch;
    logic [AW-1:0] ren_dst_arch;
    logic [SEQ_W-1:0] ren_seq;
    logic [SRC_N-1:0][PW-1:0] ren_src_phys;
    logic [SRC_N-1:0] ren_src_ready;
    logic [PW-1:0] ren_dst_phys, ren_prev_phys;
    logic cmt_valid, sq_valid, wb_valid, busy;
    logic [SEQ_W-1:0] cmt_seq, sq_seq;
    logic [PW-1:0] wb_phys;

    int checks = 0;
    int errors = 0;
    int got_acc, got_dst, got_prev;
    int saved_phys [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    rnm_rename_map #(.ARCH_N(ARCH_N), .PHYS_N(PHYS_N), .SEQ_W(SEQ_W), .SRC_N(SRC_N)) u_dut (
        .clk(clk), .rst(rst),
        .ren_valid(ren_valid), .ren_src_arch(ren_src_arch),
        .ren_dst_valid(ren_dst_valid), .ren_dst_arch(ren_dst_arch),
        .ren_seq(ren_seq), .ren_accept(ren_accept),
        .ren_src_phys(ren_src_phys), .ren_src_ready(ren_src_ready),
        .ren_dst_phys(ren_dst_phys), .ren_prev_phys(ren_prev_phys),
        .cmt_valid(cmt_valid), .cmt_seq(cmt_seq),
        .sq_valid(sq_valid), .sq_seq(sq_seq),
        .wb_valid(wb_valid), .wb_phys(wb_phys),
        .busy(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ren_valid = 0; ren_dst_valid = 0; ren_dst_arch = '0; ren_seq = '0;
        ren_src_arch = '0; cmt_valid = 0; cmt_seq = '0;
        sq_valid = 0; sq_seq = '0; wb_valid = 0; wb_phys = '0;
    endtask

    // Drive one rename at the falling edge, sample combinational results.
    task automatic do_rename(input int seq, input bit dv, input int dst);
        @(negedge clk);
        idle_inputs();
        ren_valid = 1; ren_seq = SEQ_W'(seq);
        ren_dst_valid = dv; ren_dst_arch = AW'(dst);
        #1;
        got_acc = int'(ren_accept); got_dst = int'(ren_dst_phys); got_prev = int'(ren_prev_phys);
    endtask

    // Lookup through source port 0 without a request.
    task automatic lookup(input int arch, output int phys, output int rdy);
        @(negedge clk);
        idle_inputs();
        ren_src_arch[0] = AW'(arch);
        #1;
        phys = int'(ren_src_phys[0]); rdy = int'(ren_src_ready[0]);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            idle_inputs();
            #1;
            if (!busy) return;
        end
        check("walk_timeout", 1, 0);
    endtask

    task automatic squash(input int seq);
        @(negedge clk);
        idle_inputs();
        sq_valid = 1; sq_seq = SEQ_W'(seq);
        wait_idle();
    endtask

    task automatic commit(input int seq);
        @(negedge clk);
        idle_inputs();
        cmt_valid = 1; cmt_seq = SEQ_W'(seq);
        wait_idle();
    endtask

    task automatic t_reset();
        int p, r;
        @(negedge clk); #1;
        check("R1 busy", int'(busy), 0);
        for (int a = 0; a < ARCH_N; a++) begin
            lookup(a, p, r);
            check("R1 map", p, a);
            check("R1 ready", r, 1);
        end
    endtask

    task automatic t_rename();
        int p, r;
        do_rename(1, 1, 1);
        check("R3 accept", got_acc, 1);
        check("R3 first alloc", got_dst, 8);
        check("R3 prev", got_prev, 1);
        @(negedge clk);
        idle_inputs();
        ren_valid = 1; ren_seq = 2; ren_dst_valid = 1; ren_dst_arch = 1;
        ren_src_arch[0] = 1; ren_src_arch[1] = 2;
        #1;
        check("R2 src0 phys", int'(ren_src_phys[0]), 8);
        check("R3 src0 not ready", int'(ren_src_ready[0]), 0);
        check("R2 src1 phys", int'(ren_src_phys[1]), 2);
        check("R2 src1 ready", int'(ren_src_ready[1]), 1);
        check("R3 second alloc", int'(ren_dst_phys), 9);
        check("R3 second prev", int'(ren_prev_phys), 8);
        do_rename(3, 1, 4);
        check("R3 third alloc", got_dst, 10);
        lookup(1, p, r);
        check("R3 remap", p, 9);
    endtask

    task automatic t_writeback();
        int p, r;
        lookup(1, p, r);
        check("R4 before wb", r, 0);
        @(negedge clk);
        idle_inputs();
        wb_valid = 1; wb_phys = 9;
        lookup(1, p, r);
        check("R4 after wb", r, 1);
    endtask

    task automatic t_squash();
        int p, r;
        @(negedge clk);
        idle_inputs();
        sq_valid = 1; sq_seq = 1;
        @(negedge clk);
        idle_inputs();
        ren_valid = 1;
        #1;
        check("R6 busy in walk", int'(busy), 1);
        check("R5 stall in walk", int'(ren_accept), 0);
        wait_idle();
        lookup(1, p, r);
        check("R6 restore r1", p, 8);
        lookup(4, p, r);
        check("R6 restore r4", p, 4);
        do_rename(4, 1, 5);
        check("R6 fifo reuse order", got_dst, 11);
    endtask

    task automatic t_commit();
        int p, r;
        commit(1);
        squash(0);
        lookup(1, p, r);
        check("R7 committed map kept", p, 8);
        lookup(5, p, r);
        check("R6 undo r5", p, 5);
    endtask

    task automatic t_ignored();
        int p, r;
        do_rename(10, 1, 2);
        check("R7 recycled alloc", got_dst, 12);
        commit(5);
        squash(9);
        lookup(2, p, r);
        check("R8 old commit ignored", p, 2);
        squash(9);
        lookup(2, p, r);
        check("R8 empty squash", p, 2);
    endtask

    task automatic t_full_and_race();
        int p, r;
        for (int i = 0; i < 8; i++) begin
            do_rename(20 + i, 1, i);
            check("R5 accept while free", got_acc, 1);
            if (i < 4) saved_phys[i] = got_dst;
        end
        do_rename(28, 1, 0);
        check("R5 refuse when empty", got_acc, 0);
        do_rename(28, 0, 0);
        check("R5 no-dest accepted", got_acc, 1);
        @(negedge clk);
        idle_inputs();
        sq_valid = 1; sq_seq = 23; cmt_valid = 1; cmt_seq = 27;
        wait_idle();
        for (int a = 0; a < 8; a++) begin
            lookup(a, p, r);
            check("R9 squash wins", p, (a < 4) ? saved_phys[a] : a);
        end
        commit(21);
        squash(19);
        for (int a = 0; a < 4; a++) begin
            lookup(a, p, r);
            check("R7 partial commit", p, (a < 2) ? saved_phys[a] : a);
        end
    endtask

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_rename();
        t_writeback();
        t_squash();
        t_commit();
        t_ignored();
        t_full_and_race();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule